// File: doc/BRIEF.md
# Clock gate with reset sequencer

This block drives the enable of one peripheral clock together with that peripheral's reset line. An enable request starts a timed sequence. The block first holds the peripheral in reset and waits a short settle time. It then opens the clock and waits a longer settle time. Last, it releases the reset. A disable request only closes the clock; the reset line keeps its value.

Each instance chooses with parameters whether its peripheral has a reset line at all, and which sense its clock-control bit has. Both waits are given in microseconds and turned into cycle counts from a reference clock frequency parameter. Lowering that frequency shortens the waits for simulation.

The block reports itself enabled only when the clock is open and the peripheral is out of reset. A peripheral left in reset, as after power-up, therefore looks disabled, and an enable request still runs the sequence that releases it.

Top module: `clk_gate_rst_seq`

## Requirements
- R1: After `rst_ni` is released, the clock is off (`stop_ctl_o` = 1 when `CTRL_ON_HIGH` = 0). `periph_rst_o` equals `HAS_RST`, and `busy_o` and `enabled_o` are 0.
- R2: With `HAS_RST` = 1, an enable request accepted at a clock edge drives `periph_rst_o` and `busy_o` high at that edge. The clock opens exactly `PRE_CYC` = max(1, `REF_CLK_HZ`·`PRE_US`/10^6) cycles later.
- R3: `periph_rst_o` goes low exactly `POST_CYC` = max(1, `REF_CLK_HZ`·`POST_US`/10^6) cycles after the clock opens. `busy_o` falls on the same edge, and `enabled_o` is 1 from then on.
- R4: With `HAS_RST` = 0, an enable request opens the clock on the next edge. `periph_rst_o` and `busy_o` stay 0 at all times.
- R5: `enabled_o` is 0 whenever `periph_rst_o` is 1, even with the clock open. An enable request while the peripheral is held in reset runs the full sequence.
- R6: An enable request while `enabled_o` is 1 changes no output.
- R7: `CTRL_ON_HIGH` = 0 means `stop_ctl_o` = 1 stops the clock. `CTRL_ON_HIGH` = 1 means `stop_ctl_o` = 1 runs the clock.
- R8: A disable request while idle turns the clock off on the next edge and leaves `periph_rst_o` unchanged.
- R9: While `busy_o` is 1, enable and disable requests are ignored.
- R10: When enable and disable are requested in the same idle cycle, the disable is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | Enable request, sampled each cycle |
| dis_req_i | input | 1 | Disable request, sampled each cycle |
| stop_ctl_o | output | 1 | Clock-control bit, sense set by `CTRL_ON_HIGH` |
| periph_rst_o | output | 1 | Peripheral reset, 1 = held in reset |
| busy_o | output | 1 | Enable sequence in progress |
| enabled_o | output | 1 | Clock open and peripheral out of reset |

## Verification
The enable sequence is run from three starting points: the power-up state with the reset held, the disabled state with the reset already released, and the enabled state. These separate a real sequence from the ignored case and show that a held reset is still cleared. Requests are injected during both waits, which shows whether the hold-off covers the whole sequence. Simultaneous requests, and a second instance with no reset line and the opposite bit sense, cover the priority and parameter variants. A fixed-seed random run of request mixes is then compared cycle by cycle against a bench model.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_SETTLE} cgr_state_e;

  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1000000;
    return (c == 0) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/cgr_timer.sv
module cgr_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cgr_fsm.sv
module cgr_fsm
  import cgr_pkg::*;
#(
  parameter bit          HAS_RST  = 1'b1,
  parameter int unsigned W        = 8,
  parameter int unsigned PRE_CYC  = 4,
  parameter int unsigned POST_CYC = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_req_i,
  input  logic         dis_req_i,
  input  logic         zero_i,
  output logic         clk_on_o,
  output logic         prst_o,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o
);
  cgr_state_e state_q;
  logic       clk_on_q, prst_q, is_en, start;

  assign is_en = clk_on_q & ~prst_q;
  // disable wins over enable in the same cycle
  assign start = (state_q == ST_IDLE) & en_req_i & ~dis_req_i & ~is_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      clk_on_q <= 1'b0;
      prst_q   <= HAS_RST;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (dis_req_i) clk_on_q <= 1'b0;
          else if (start) begin
            if (HAS_RST) begin
              prst_q  <= 1'b1;
              state_q <= ST_HOLD;
            end else begin
              clk_on_q <= 1'b1;
            end
          end
        end
        ST_HOLD: if (zero_i) begin
          clk_on_q <= 1'b1;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (zero_i) begin
          prst_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o     = start | ((state_q == ST_HOLD) & zero_i);
  assign load_val_o = (state_q == ST_IDLE) ? W'(PRE_CYC - 1) : W'(POST_CYC - 1);
  assign clk_on_o   = clk_on_q;
  assign prst_o     = prst_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/cgr_out.sv
module cgr_out #(
  parameter bit CTRL_ON_HIGH = 1'b0
) (
  input  logic clk_on_i,
  input  logic prst_i,
  output logic stop_ctl_o,
  output logic enabled_o
);
  if (CTRL_ON_HIGH) begin : g_on_high
    assign stop_ctl_o = clk_on_i;
  end else begin : g_stop_high
    assign stop_ctl_o = ~clk_on_i;
  end

  assign enabled_o = clk_on_i & ~prst_i;
endmodule

// File: rtl/clk_gate_rst_seq.sv
module clk_gate_rst_seq #(
  parameter int unsigned REF_CLK_HZ   = 24_000_000,
  parameter int unsigned PRE_US       = 100,
  parameter int unsigned POST_US      = 10_000,
  parameter bit          HAS_RST      = 1'b1,
  parameter bit          CTRL_ON_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  output logic stop_ctl_o,
  output logic periph_rst_o,
  output logic busy_o,
  output logic enabled_o
);
  localparam int unsigned PRE_CYC  = cgr_pkg::us_to_cycles(REF_CLK_HZ, PRE_US);
  localparam int unsigned POST_CYC = cgr_pkg::us_to_cycles(REF_CLK_HZ, POST_US);
  localparam int unsigned MAX_CYC  = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int unsigned W        = $clog2(MAX_CYC + 1);

  logic         clk_on, prst, zero, load;
  logic [W-1:0] load_val;

  cgr_fsm #(
    .HAS_RST(HAS_RST), .W(W), .PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_req_i(en_req_i), .dis_req_i(dis_req_i),
    .zero_i(zero), .clk_on_o(clk_on), .prst_o(prst), .busy_o(busy_o),
    .load_o(load), .load_val_o(load_val)
  );

  if (HAS_RST) begin : g_timer
    cgr_timer #(.W(W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
      .load_val_i(load_val), .zero_o(zero)
    );
  end else begin : g_no_timer
    assign zero = 1'b1;
  end

  cgr_out #(.CTRL_ON_HIGH(CTRL_ON_HIGH)) u_out (
    .clk_on_i(clk_on), .prst_i(prst),
    .stop_ctl_o(stop_ctl_o), .enabled_o(enabled_o)
  );

  assign periph_rst_o = prst;
endmodule

// File: rtl/cgr_checker.sv
module cgr_checker #(
  parameter bit          HAS_RST      = 1'b1,
  parameter bit          CTRL_ON_HIGH = 1'b0,
  parameter int unsigned PRE_CYC      = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_req_i,
  input logic dis_req_i,
  input logic stop_ctl_o,
  input logic periph_rst_o,
  input logic busy_o,
  input logic enabled_o
);
  logic        clk_on_w;
  logic [31:0] age_q;

  assign clk_on_w = CTRL_ON_HIGH ? stop_ctl_o : ~stop_ctl_o;

  // cycles spent busy with the clock still off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= (busy_o && !clk_on_w) ? age_q + 1 : '0;
  end

  a_r2_settle_before_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_RST && $rose(clk_on_w)) |-> (periph_rst_o && age_q == PRE_CYC));

  a_r3_release_after_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(periph_rst_o) |-> (clk_on_w && $past(clk_on_w) && !busy_o && enabled_o));

  a_r4_no_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_RST |-> (!periph_rst_o && !busy_o));

  a_r6_enabled_ignores_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && en_req_i && !dis_req_i) |=>
      ($stable(stop_ctl_o) && $stable(periph_rst_o) && !busy_o));

  a_r8_disable_leaves_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && dis_req_i) |=> ($stable(periph_rst_o) && !clk_on_w));

  a_r9_busy_blocks_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !$fell(clk_on_w));
endmodule

bind clk_gate_rst_seq cgr_checker #(
  .HAS_RST(HAS_RST), .CTRL_ON_HIGH(CTRL_ON_HIGH), .PRE_CYC(PRE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_req_i(en_req_i), .dis_req_i(dis_req_i),
  .stop_ctl_o(stop_ctl_o), .periph_rst_o(periph_rst_o), .busy_o(busy_o),
  .enabled_o(enabled_o)
);

// File: tb/tb_clk_gate_rst_seq.sv
`timescale 1ns/1ps
module tb_clk_gate_rst_seq;
  localparam int unsigned HZ   = 200_000;
  localparam int unsigned PRE  = HZ * 100 / 1_000_000;    // 20
  localparam int unsigned POST = HZ * 10_000 / 1_000_000; // 2000

  logic clk = 1'b0, rst_ni = 1'b0, en_r = 1'b0, dis_r = 1'b0;
  logic stop_a, prst_a, busy_a, en_a;
  logic stop_b, prst_b, busy_b, en_b;

  always #4 clk = ~clk;

  clk_gate_rst_seq #(.REF_CLK_HZ(HZ), .HAS_RST(1'b1), .CTRL_ON_HIGH(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_req_i(en_r), .dis_req_i(dis_r),
    .stop_ctl_o(stop_a), .periph_rst_o(prst_a), .busy_o(busy_a), .enabled_o(en_a));

  clk_gate_rst_seq #(.REF_CLK_HZ(HZ), .HAS_RST(1'b0), .CTRL_ON_HIGH(1'b1)) dut_nr (
    .clk_i(clk), .rst_ni(rst_ni), .en_req_i(en_r), .dis_req_i(dis_r),
    .stop_ctl_o(stop_b), .periph_rst_o(prst_b), .busy_o(busy_b), .enabled_o(en_b));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur = "R1";

  // bench model
  bit m_on, m_rst, m_busy, m_post, n_on;
  int m_wait;

  task automatic check(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step(input bit en, input bit dis);
    if (m_busy) begin
      m_wait--;
      if (m_wait == 0) begin
        if (!m_post) begin m_on = 1; m_post = 1; m_wait = POST; end
        else begin m_rst = 0; m_busy = 0; end
      end
    end else if (dis) m_on = 0;
    else if (en && !(m_on && !m_rst)) begin
      m_rst = 1; m_busy = 1; m_post = 0; m_wait = PRE;
    end
    if (dis) n_on = 0; else if (en) n_on = 1;
  endtask

  task automatic compare_all();
    string t;
    t = m_busy ? (m_post ? "R3" : "R2") : cur;
    check(t, stop_a, !m_on);
    check(t, prst_a, m_rst);
    check(t, busy_a, m_busy);
    check(t, en_a, m_on && !m_rst);
    check("R4", stop_b, n_on);
    check("R4", prst_b, 1'b0);
    check("R4", busy_b, 1'b0);
    check("R4", en_b, n_on);
  endtask

  task automatic cycle(input bit en, input bit dis);
    en_r = en; dis_r = dis;
    @(posedge clk);
    model_step(en, dis);
    @(negedge clk);
    en_r = 1'b0; dis_r = 1'b0;
    compare_all();
  endtask

  task automatic wait_idle();
    while (m_busy) cycle(1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_on = 0; m_rst = 1; m_busy = 0; m_post = 0; m_wait = 0; n_on = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cur = "R1";
    compare_all();
    check("R1", stop_a, 1'b1);
    check("R1", prst_a, 1'b1);

    // enable from the held-reset power-up state
    cur = "R5";
    cycle(1'b1, 1'b0);
    check("R5", busy_a, 1'b1);
    while (!m_post) cycle(1'b0, 1'b0);
    check("R5", stop_a, 1'b0);   // clock open
    check("R5", en_a, 1'b0);     // but still in reset
    wait_idle();
    check("R5", en_a, 1'b1);

    cur = "R6";
    cycle(1'b1, 1'b0);
    check("R6", busy_a, 1'b0);
    check("R6", prst_a, 1'b0);

    cur = "R8";
    cycle(1'b0, 1'b1);
    check("R8", prst_a, 1'b0);
    check("R8", stop_a, 1'b1);

    check("R7", stop_a, 1'b1);   // off, stop-high sense
    check("R7", stop_b, 1'b0);   // off, run-high sense

    // requests during both waits
    cur = "R9";
    cycle(1'b1, 1'b0);
    repeat (5) cycle(1'b0, 1'b1);
    repeat (3) cycle(1'b1, 1'b0);
    while (!m_post) cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    check("R9", stop_a, 1'b0);
    wait_idle();
    check("R9", en_a, 1'b1);

    cur = "R10";
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    check("R10", busy_a, 1'b0);
    check("R10", stop_a, 1'b1);
    check("R10", stop_b, 1'b0);

    // enable from disabled with reset already released
    cur = "R2";
    cycle(1'b1, 1'b0);
    check("R2", prst_a, 1'b1);
    wait_idle();
    check("R3", en_a, 1'b1);

    cur = "R8";
    for (int i = 0; i < 40; i++) begin
      int unsigned op;
      op = $urandom % 4;
      cycle(op[0], op[1]);
      if (($urandom % 3) != 0) wait_idle();
    end
    wait_idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule